// File: doc/BRIEF.md
# Page Translation Lookaside Cache

This block maps 32-bit logical addresses to physical addresses. It keeps a small fully associative store of recently used page descriptors, and it has two transparent windows. A window passes a logical range through unchanged, so no descriptor is needed for that range.

Each lookup carries an address, a function code and a write flag. A lookup that finds a descriptor returns its physical address in the next cycle. A lookup that finds no descriptor raises a table-walk request and then blocks. Logic outside the block searches the tables in memory and returns the descriptor through a refill port. The refill writes the descriptor into the store and completes the stalled lookup. A flush input clears the store, and a small configuration port sets the page size and the two windows.

Top module: `xlat_cache`

## Requirements
- R1: The store holds 22 descriptors at once. Any descriptor can sit in any slot, so 22 distinct pages loaded one after another all hit afterwards.
- R2: An accepted lookup that hits gives `rsp_valid` and `rsp_hit` one cycle after the request. The address bits above the page offset come from the descriptor's physical page, and the offset bits come from the logical address.
- R3: An accepted lookup that finds no descriptor pulses `rsp_miss` one cycle later and raises `walk_req`, with the address on `walk_addr`. `walk_req` stays high until a refill arrives. Lookups presented while `walk_req` is high are ignored: no response and no state change.
- R4: A refill while `walk_req` is high stores the descriptor under the stalled page and function code and drops `walk_req`. One cycle later it reports the stalled lookup as a hit, with the translated address and the descriptor's cache-inhibit and modified flags.
- R5: Configuration write select 0 takes the page size from data bits [2:0] as n, giving 2^(8+n) bytes (256 B up to 32 KB). The page compare and the translation ignore all offset bits of that size.
- R6: Writing a page size that differs from the current one invalidates every descriptor. Writing the same value leaves them intact.
- R7: Selects 1 and 2 program the two windows. In each, bit 15 enables the window, bits [31:24] are the base, and bits [22:16] mark which of address bits [30:24] are ignored. An access inside an enabled window reports `rsp_tt` with the physical address equal to the logical address. It does not consult or miss in the store, even when a descriptor would match.
- R8: The function code is part of the tag. The same page with a different function code misses.
- R9: A write that hits a write-protected page sets `rsp_fault` and leaves the stored modified flag unchanged. A write that hits an unprotected page sets the flag. `rsp_mod` shows the flag after the access.
- R10: A refill goes to the lowest-numbered invalid slot when one exists. Otherwise it replaces the slot named by a round-robin pointer. The pointer starts at 0, advances after each use and wraps from 21 to 0.
- R11: `flush` invalidates every descriptor in a single cycle.
- R12: A refill that arrives when no walk is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Logical address |
| req_fc | input | 3 | Function code |
| req_write | input | 1 | Access is a write |
| refill_valid | input | 1 | Descriptor delivered |
| refill_ppage | input | 24 | Physical page, address bits [31:8] |
| refill_wp | input | 1 | Write-protect flag |
| refill_ci | input | 1 | Cache-inhibit flag |
| refill_mod | input | 1 | Modified flag as stored in the table |
| flush | input | 1 | Invalidate all descriptors |
| cfg_we | input | 1 | Configuration write |
| cfg_sel | input | 2 | 0 page size, 1 window A, 2 window B |
| cfg_data | input | 32 | Configuration value |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Translated through a descriptor |
| rsp_miss | output | 1 | No descriptor, walk started |
| rsp_tt | output | 1 | Passed through a transparent window |
| rsp_fault | output | 1 | Write to a protected page |
| rsp_mod | output | 1 | Modified flag after the access |
| rsp_ci | output | 1 | Cache-inhibit flag of the page |
| rsp_paddr | output | 32 | Physical address |
| walk_req | output | 1 | Table walk pending |
| walk_addr | output | 32 | Address that missed |

## Verification
Corrupted tag or valid state appears at the ports one cycle after the next lookup of the affected page, as a miss where a hit is due or the reverse. A wrong replacement pointer stays hidden until the store is full. It then shows on the first revisit of an evicted page. A lost modified update waits for the next access to that page, and a page-size error shows in the translated offset bits of the very next hit. The bench keeps its own model of the store and compares every response field on every cycle, so each such fault is caught at its first visible cycle.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int NENT = 22,
  parameter int FCW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [31:0]     req_addr,
  input  logic [FCW-1:0]  req_fc,
  input  logic            req_write,
  input  logic            refill_valid,
  input  logic [23:0]     refill_ppage,
  input  logic            refill_wp,
  input  logic            refill_ci,
  input  logic            refill_mod,
  input  logic            flush,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [31:0]     cfg_data,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_miss,
  output logic            rsp_tt,
  output logic            rsp_fault,
  output logic            rsp_mod,
  output logic            rsp_ci,
  output logic [31:0]     rsp_paddr,
  output logic            walk_req,
  output logic [31:0]     walk_addr
);
  localparam int IW  = $clog2(NENT);
  localparam int PGW = 24;

  logic [2:0]      pgsz;
  logic [31:0]     tt0, tt1;
  logic [NENT-1:0] v, wp, md, ci;
  logic [PGW-1:0]  lp [NENT];
  logic [PGW-1:0]  pp [NENT];
  logic [FCW-1:0]  fc [NENT];
  logic [IW-1:0]   rr, hidx, fidx, vic;
  logic            hit, fany;
  logic [FCW-1:0]  pfc;
  logic            pwr;

  function automatic logic tt_match(input logic [31:0] r, input logic [31:0] a);
    return r[15] && (((a[31:24] ^ r[31:24]) & ~{1'b0, r[22:16]}) == 8'h00);
  endfunction

  wire [PGW-1:0] pmask  = ~((PGW'(1) << pgsz) - PGW'(1));
  wire [31:0]    amask  = {pmask, 8'h00};
  wire           tt_hit = tt_match(tt0, req_addr) || tt_match(tt1, req_addr);
  wire           take   = req_valid && !walk_req;
  wire           fill   = refill_valid && walk_req;
  wire           pg_chg = cfg_we && cfg_sel == 2'd0 && cfg_data[2:0] != pgsz;
  wire           wr_ok  = req_write && !wp[hidx];
  wire           fmod   = refill_mod || (pwr && !refill_wp);

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    fany = 1'b0;
    fidx = '0;
    for (int i = 0; i < NENT; i++) begin
      if (!hit && v[i] && fc[i] == req_fc && ((lp[i] ^ req_addr[31:8]) & pmask) == '0) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
      if (!fany && !v[i]) begin
        fany = 1'b1;
        fidx = IW'(i);
      end
    end
    vic = fany ? fidx : rr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v <= '0; wp <= '0; md <= '0; ci <= '0;
      rr <= '0; pgsz <= '0; tt0 <= '0; tt1 <= '0;
      walk_req <= 1'b0; walk_addr <= '0; pfc <= '0; pwr <= 1'b0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0; rsp_tt <= 1'b0;
      rsp_fault <= 1'b0; rsp_mod <= 1'b0; rsp_ci <= 1'b0; rsp_paddr <= '0;
    end else begin
      rsp_valid <= take || fill;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_tt    <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_mod   <= 1'b0;
      rsp_ci    <= 1'b0;
      if (cfg_we)
        case (cfg_sel)
          2'd0:    pgsz <= cfg_data[2:0];
          2'd1:    tt0  <= cfg_data;
          2'd2:    tt1  <= cfg_data;
          default: ;
        endcase
      if (take) begin
        if (tt_hit) begin
          rsp_tt    <= 1'b1;
          rsp_paddr <= req_addr;
        end else if (hit) begin
          rsp_hit   <= 1'b1;
          rsp_paddr <= ({pp[hidx], 8'h00} & amask) | (req_addr & ~amask);
          rsp_fault <= req_write && wp[hidx];
          rsp_mod   <= md[hidx] || wr_ok;
          rsp_ci    <= ci[hidx];
          if (wr_ok) md[hidx] <= 1'b1;
        end else begin
          rsp_miss  <= 1'b1;
          walk_req  <= 1'b1;
          walk_addr <= req_addr;
          pfc       <= req_fc;
          pwr       <= req_write;
        end
      end else if (fill) begin
        walk_req  <= 1'b0;
        v[vic]    <= 1'b1;
        lp[vic]   <= walk_addr[31:8];
        fc[vic]   <= pfc;
        pp[vic]   <= refill_ppage;
        wp[vic]   <= refill_wp;
        ci[vic]   <= refill_ci;
        md[vic]   <= fmod;
        rsp_hit   <= 1'b1;
        rsp_paddr <= ({refill_ppage, 8'h00} & amask) | (walk_addr & ~amask);
        rsp_fault <= pwr && refill_wp;
        rsp_mod   <= fmod;
        rsp_ci    <= refill_ci;
        if (!fany) rr <= (rr == IW'(NENT - 1)) ? '0 : rr + 1'b1;
      end
      if (flush || pg_chg) v <= '0;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);
  p_miss_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_req) |-> rsp_miss);
  p_walk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !refill_valid) |=> (walk_req && $stable(walk_addr)));
  p_one_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_tt}) == 1);
  p_window_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tt_hit) |=> (rsp_tt && rsp_paddr == $past(req_addr)));
  p_protect_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !tt_hit && hit && req_write && wp[hidx] && !flush) |=>
      (rsp_fault && md == $past(md)));
  p_rr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rr < IW'(NENT));
  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> v == '0);
  p_stray_refill_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid && !walk_req && !req_valid) |=> !rsp_valid);
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  localparam int N = 22;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_write, refill_valid, refill_wp, refill_ci, refill_mod;
  logic        flush, cfg_we;
  logic [31:0] req_addr, cfg_data;
  logic [2:0]  req_fc;
  logic [23:0] refill_ppage;
  logic [1:0]  cfg_sel;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_tt, rsp_fault, rsp_mod, rsp_ci, walk_req;
  logic [31:0] rsp_paddr, walk_addr;

  xlat_cache uut (.*);

  int    checks = 0, errors = 0;
  string tag = "reset";

  bit        mv [N];
  bit [2:0]  mfc [N];
  bit [31:0] mla [N];
  bit [23:0] mpp [N];
  bit        mwp [N], mmd [N], mci [N];
  int        mrr, mps;
  bit [31:0] mt0, mt1, mwa, e_pa;
  bit        mwalk, mwwr;
  bit [2:0]  mwfc;
  bit        e_valid, e_hit, e_miss, e_tt, e_fault, e_mod, e_ci;

  function automatic bit ttm(bit [31:0] r, bit [31:0] a);
    if (!r[15]) return 1'b0;
    for (int b = 24; b <= 31; b++)
      if (!(b < 31 && r[b-8]) && a[b] != r[b]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit [31:0] xl(bit [23:0] p, bit [31:0] a, int ps);
    int sh = 8 + ps;
    bit [31:0] base = {p, 8'h00};
    return ((base >> sh) << sh) | (a & ((32'd1 << sh) - 1));
  endfunction

  always @(posedge clk) begin
    int hi, vi;
    bit chg;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; mmd[i] = 0; end
      mrr = 0; mps = 0; mt0 = 0; mt1 = 0; mwalk = 0; mwa = 0;
      {e_valid, e_hit, e_miss, e_tt, e_fault, e_mod, e_ci} = '0;
    end else begin
      {e_valid, e_hit, e_miss, e_tt, e_fault, e_mod, e_ci} = '0;
      chg = cfg_we && cfg_sel == 2'd0 && int'(cfg_data[2:0]) != mps;
      if (req_valid && !mwalk) begin
        e_valid = 1;
        if (ttm(mt0, req_addr) || ttm(mt1, req_addr)) begin
          e_tt = 1; e_pa = req_addr;
        end else begin
          hi = -1;
          for (int i = 0; i < N; i++)
            if (hi < 0 && mv[i] && mfc[i] == req_fc && (mla[i] >> (8 + mps)) == (req_addr >> (8 + mps)))
              hi = i;
          if (hi >= 0) begin
            e_hit = 1;
            e_pa = xl(mpp[hi], req_addr, mps);
            e_fault = req_write && mwp[hi];
            if (req_write && !mwp[hi]) mmd[hi] = 1;
            e_mod = mmd[hi];
            e_ci = mci[hi];
          end else begin
            e_miss = 1; mwalk = 1; mwa = req_addr; mwfc = req_fc; mwwr = req_write;
          end
        end
      end else if (refill_valid && mwalk) begin
        vi = -1;
        for (int i = 0; i < N; i++) if (vi < 0 && !mv[i]) vi = i;
        if (vi < 0) begin vi = mrr; mrr = (mrr + 1) % N; end
        mv[vi] = 1; mla[vi] = mwa; mfc[vi] = mwfc; mpp[vi] = refill_ppage;
        mwp[vi] = refill_wp; mci[vi] = refill_ci;
        mmd[vi] = refill_mod || (mwwr && !refill_wp);
        e_valid = 1; e_hit = 1;
        e_pa = xl(refill_ppage, mwa, mps);
        e_fault = mwwr && refill_wp; e_mod = mmd[vi]; e_ci = refill_ci;
        mwalk = 0;
      end
      if (cfg_we)
        case (cfg_sel)
          2'd0: mps = int'(cfg_data[2:0]);
          2'd1: mt0 = cfg_data;
          2'd2: mt1 = cfg_data;
          default: ;
        endcase
      if (flush || chg) for (int i = 0; i < N; i++) mv[i] = 0;
    end
  end

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(rsp_valid == e_valid, "valid", 32'(rsp_valid), 32'(e_valid));
    chk(walk_req == mwalk, "walk_req", 32'(walk_req), 32'(mwalk));
    if (mwalk) chk(walk_addr == mwa, "walk_addr", walk_addr, mwa);
    chk(rsp_hit == e_hit, "hit", 32'(rsp_hit), 32'(e_hit));
    chk(rsp_miss == e_miss, "miss", 32'(rsp_miss), 32'(e_miss));
    chk(rsp_tt == e_tt, "tt", 32'(rsp_tt), 32'(e_tt));
    chk(rsp_fault == e_fault, "fault", 32'(rsp_fault), 32'(e_fault));
    chk(rsp_mod == e_mod, "mod", 32'(rsp_mod), 32'(e_mod));
    chk(rsp_ci == e_ci, "ci", 32'(rsp_ci), 32'(e_ci));
    if (e_valid) chk(rsp_paddr == e_pa, "paddr", rsp_paddr, e_pa);
  end

  task automatic idle();
    req_valid = 0; refill_valid = 0; cfg_we = 0; flush = 0;
  endtask

  task automatic acc(logic [31:0] a, logic [2:0] f, logic w);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_fc = f; req_write = w;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic fill(logic [23:0] p, logic w, logic c, logic m);
    @(negedge clk);
    refill_valid = 1; refill_ppage = p; refill_wp = w; refill_ci = c; refill_mod = m;
    @(negedge clk);
    refill_valid = 0;
  endtask

  task automatic cfg(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic load(logic [31:0] a, logic [2:0] f, logic [23:0] p);
    acc(a, f, 1'b0);
    if (walk_req) fill(p, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); req_addr = 0; req_fc = 0; req_write = 0;
    refill_ppage = 0; refill_wp = 0; refill_ci = 0; refill_mod = 0;
    cfg_sel = 0; cfg_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_valid && !walk_req, "reset outputs", {30'd0, rsp_valid, walk_req}, 0);

    tag = "R3";
    acc(32'h0001_2345, 3'd1, 0);
    chk(rsp_miss && walk_addr == 32'h0001_2345, "R3 miss", walk_addr, 32'h0001_2345);
    acc(32'h0001_2345, 3'd1, 0);
    chk(!rsp_valid && walk_req, "R3 ignored while walking", 32'(rsp_valid), 0);
    tag = "R4";
    fill(24'h00ABCD, 0, 1, 0);
    chk(rsp_hit && rsp_ci && rsp_paddr == 32'h00AB_CD45, "R4 refill result", rsp_paddr, 32'h00AB_CD45);
    tag = "R2";
    acc(32'h0001_2345, 3'd1, 0);
    chk(rsp_hit && rsp_paddr == 32'h00AB_CD45, "R2 hit", rsp_paddr, 32'h00AB_CD45);
    tag = "R8";
    acc(32'h0001_2345, 3'd2, 0);
    chk(rsp_miss, "R8 other fc", 32'(rsp_miss), 1);
    fill(24'h00BEEF, 0, 0, 0);
    tag = "R12";
    fill(24'h000001, 0, 0, 0);
    chk(!rsp_valid, "R12 stray refill", 32'(rsp_valid), 0);
    acc(32'h0001_2345, 3'd1, 0);
    chk(rsp_paddr == 32'h00AB_CD45, "R12 entry unchanged", rsp_paddr, 32'h00AB_CD45);

    tag = "R9";
    acc(32'h2000_0100, 3'd5, 0);
    fill(24'h300001, 1, 0, 0);
    acc(32'h2000_0104, 3'd5, 1);
    chk(rsp_fault && !rsp_mod, "R9 protected write", {30'd0, rsp_fault, rsp_mod}, 32'h2);
    acc(32'h2000_0108, 3'd5, 0);
    chk(!rsp_mod, "R9 mod unchanged", 32'(rsp_mod), 0);
    acc(32'h0001_2300, 3'd1, 1);
    chk(rsp_mod && !rsp_fault, "R9 mod set", 32'(rsp_mod), 1);

    tag = "R1";
    do_flush();
    for (int i = 0; i < N; i++) load(32'(i) << 8, 3'd1, 24'h100 + 24'(i));
    for (int i = 0; i < N; i++) begin
      acc(32'(i) << 8, 3'd1, 0);
      chk(rsp_hit && rsp_paddr == ((32'h100 + 32'(i)) << 8), "R1 all resident", rsp_paddr, (32'h100 + 32'(i)) << 8);
    end
    tag = "R10";
    load(32'h0000_7700, 3'd1, 24'h999);
    acc(32'h0000_0000, 3'd1, 0);
    chk(rsp_miss, "R10 slot 0 replaced", 32'(rsp_miss), 1);
    fill(24'h100, 0, 0, 0);
    acc(32'h0000_0100, 3'd1, 0);
    chk(rsp_miss, "R10 pointer advanced to slot 1", 32'(rsp_miss), 1);
    fill(24'h101, 0, 0, 0);
    acc(32'h0000_0300, 3'd1, 0);
    chk(rsp_hit, "R10 slot 3 kept", 32'(rsp_hit), 1);

    tag = "R11";
    do_flush();
    acc(32'h0000_0300, 3'd1, 0);
    chk(rsp_miss, "R11 flushed", 32'(rsp_miss), 1);
    fill(24'h103, 0, 0, 0);

    tag = "R5";
    cfg(2'd0, 32'd4);
    acc(32'h0003_4FFC, 3'd1, 0);
    chk(rsp_miss, "R5 size change invalidated", 32'(rsp_miss), 1);
    fill(24'h000777, 0, 0, 0);
    chk(rsp_paddr == 32'h0007_7FFC, "R5 refill 4K", rsp_paddr, 32'h0007_7FFC);
    acc(32'h0003_4010, 3'd1, 0);
    chk(rsp_hit && rsp_paddr == 32'h0007_7010, "R5 4K offset", rsp_paddr, 32'h0007_7010);
    tag = "R6";
    cfg(2'd0, 32'd4);
    acc(32'h0003_4020, 3'd1, 0);
    chk(rsp_hit, "R6 same size keeps", 32'(rsp_hit), 1);
    cfg(2'd0, 32'd7);
    acc(32'h0003_4020, 3'd1, 0);
    chk(rsp_miss, "R6 new size flushes", 32'(rsp_miss), 1);
    fill(24'h000800, 0, 0, 0);

    tag = "R7";
    cfg(2'd1, 32'h4001_8000);
    acc(32'h4123_4567, 3'd1, 1);
    chk(rsp_tt && rsp_paddr == 32'h4123_4567, "R7 window", rsp_paddr, 32'h4123_4567);
    acc(32'h4023_0000, 3'd1, 0);
    chk(rsp_tt, "R7 ignored bit", 32'(rsp_tt), 1);
    acc(32'h4223_0000, 3'd1, 0);
    chk(rsp_miss, "R7 outside window", 32'(rsp_miss), 1);
    fill(24'h000900, 0, 0, 0);
    cfg(2'd2, 32'h4200_8000);
    acc(32'h4223_0000, 3'd1, 0);
    chk(rsp_tt && !rsp_hit, "R7 window over entry", 32'(rsp_tt), 1);
    cfg(2'd2, 32'h8000_0000);
    acc(32'h8000_0000, 3'd1, 0);
    chk(rsp_miss, "R7 disabled window", 32'(rsp_miss), 1);
    fill(24'h000A00, 0, 0, 0);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule